// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two integer operands over many clock cycles and returns a product twice as wide. A request is made by pulsing `start` while the block is idle. The operands and the `signed_mode` flag are captured on that edge. The block then works through the multiplier one bit per clock. In each step the running sum takes in the multiplicand when the current low multiplier bit is set. In the same cycle the double-width multiplicand register moves one place left and the multiplier register moves one place right.

Signed requests are handled outside the shift-add core. Each operand is reduced to its magnitude as an unsigned number, so the most negative input becomes the unsigned value 2^31. The core multiplies the two magnitudes. A final stage negates the sum when exactly one operand was negative and writes the result to the output register, together with a one-cycle `done` pulse.

While a request is in flight, `busy` is high and the block takes no notice of `start`. The product output keeps its last result until the next request completes.

Top module: `shift_add_mul`

## Requirements
- R1: With `busy` low, a `start` high at a rising edge captures `op_a`, `op_b` and `signed_mode`, and `busy` reads high after that edge.
- R2: With `signed_mode` = 0, the result equals the operands read as unsigned 32-bit integers and multiplied into a 64-bit unsigned product.
- R3: With `signed_mode` = 1, the result equals the operands read as two's-complement integers and multiplied into a 64-bit two's-complement product. This holds for -2^31 (0x80000000) in either operand.
- R4: `done` rises after exactly 33 rising edges following the accepting edge: 32 shift-add steps and one sign stage. `done` stays low before that.
- R5: `done` is high for exactly one cycle, and `busy` falls on the same edge that `done` rises.
- R6: While `busy` is high, `start` and any change of `op_a`, `op_b` or `signed_mode` have no effect on the result in progress or on when it completes.
- R7: `product` changes only on the edge that raises `done`; between completions it holds its value.
- R8: While `rst_n` is low and after its release, `busy` = 0, `done` = 0 and `product` = 0 until a request completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| start | input | 1 | Request pulse, taken only while idle |
| signed_mode | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| op_a | input | 32 | Multiplicand |
| op_b | input | 32 | Multiplier |
| busy | output | 1 | High from the accepting edge until the completing edge |
| done | output | 1 | One-cycle pulse when `product` is updated |
| product | output | 64 | Last completed product, held between completions |

## Verification
The bench drives `start` at a falling edge, so the accepting rising edge follows half a period later. It samples half a period after each later rising edge. `busy` is due right after the accepting edge. `done` must stay low over the next 32 samples and be high, with `busy` low and the correct product, at the 33rd. It must be low again one cycle later. In the middle of the run, the held output is compared with the previous result, and on chosen runs the inputs are disturbed to show that a request in flight ignores them. The checker module counts the cycles from acceptance and compares the completion cycle and the product with a model built from the captured operands.

// File: rtl/shmul_pkg.sv
package shmul_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } mul_state_e;

endpackage

// File: rtl/mul_rst_sync.sv
module mul_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/mul_magnitude.sv
module mul_magnitude #(
  parameter int W = 32
) (
  input  logic [W-1:0] val,
  input  logic         is_signed,
  output logic [W-1:0] mag,
  output logic         neg
);

  always_comb begin
    neg = is_signed & val[W-1];
    if (neg) begin
      mag = (~val) + W'(1);
    end else begin
      mag = val;
    end
  end

endmodule

// File: rtl/mul_ctrl.sv
module mul_ctrl
  import shmul_pkg::*;
#(
  parameter int STEPS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step,
  output logic finish,
  output logic busy,
  output logic done
);

  localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  mul_state_e      state_q, state_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            cnt_en;
  logic            done_q, done_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    load    = 1'b0;
    step    = 1'b0;
    finish  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          load    = 1'b1;
          cnt_d   = '0;
          state_d = ST_RUN;
        end
      end
      ST_RUN: begin
        step = 1'b1;
        if (cnt_q == LAST) begin
          state_d = ST_FIX;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      ST_FIX: begin
        finish  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
    cnt_en = load | step;
    done_d = finish;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign busy = (state_q != ST_IDLE);
  assign done = done_q;

endmodule

// File: rtl/mul_datapath.sv
module mul_datapath #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic           finish,
  input  logic [W-1:0]   mag_a,
  input  logic [W-1:0]   mag_b,
  input  logic           neg_in,
  output logic [2*W-1:0] product
);

  localparam int PW = 2 * W;

  logic [PW-1:0] mcand_q, mcand_d;
  logic [W-1:0]  mplr_q, mplr_d;
  logic [PW-1:0] acc_q, acc_d;
  logic          neg_q;
  logic [PW-1:0] prod_q, prod_d;
  logic          work_en;

  always_comb begin
    work_en = load | step;
    if (load) begin
      mcand_d = {{W{1'b0}}, mag_a};
      mplr_d  = mag_b;
      acc_d   = '0;
    end else begin
      mcand_d = mcand_q << 1;
      mplr_d  = mplr_q >> 1;
      acc_d   = acc_q + (mplr_q[0] ? mcand_q : '0);
    end
    prod_d = neg_q ? ((~acc_q) + PW'(1)) : acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q <= '0;
      mplr_q  <= '0;
      acc_q   <= '0;
    end else if (work_en) begin
      mcand_q <= mcand_d;
      mplr_q  <= mplr_d;
      acc_q   <= acc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      neg_q <= 1'b0;
    end else if (load) begin
      neg_q <= neg_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q <= '0;
    end else if (finish) begin
      prod_q <= prod_d;
    end
  end

  assign product = prod_q;

endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul #(
  parameter int OP_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            signed_mode,
  input  logic [OP_W-1:0] op_a,
  input  logic [OP_W-1:0] op_b,
  output logic            busy,
  output logic            done,
  output logic [2*OP_W-1:0] product
);

  localparam int NOPS = 2;

  logic                       rst_sync_n;
  logic                       load, step, finish;
  logic [NOPS-1:0][OP_W-1:0]  raw_op;
  logic [NOPS-1:0][OP_W-1:0]  mag_op;
  logic [NOPS-1:0]            neg_op;

  assign raw_op[0] = op_a;
  assign raw_op[1] = op_b;

  mul_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar g = 0; g < NOPS; g++) begin : g_mag
    mul_magnitude #(.W(OP_W)) u_mag (
      .val       (raw_op[g]),
      .is_signed (signed_mode),
      .mag       (mag_op[g]),
      .neg       (neg_op[g])
    );
  end

  mul_ctrl #(.STEPS(OP_W)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .start  (start),
    .load   (load),
    .step   (step),
    .finish (finish),
    .busy   (busy),
    .done   (done)
  );

  mul_datapath #(.W(OP_W)) u_dp (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load    (load),
    .step    (step),
    .finish  (finish),
    .mag_a   (mag_op[0]),
    .mag_b   (mag_op[1]),
    .neg_in  (neg_op[0] ^ neg_op[1]),
    .product (product)
  );

endmodule

// File: rtl/shmul_chk.sv
module shmul_chk #(
  parameter int OP_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              signed_mode,
  input logic [OP_W-1:0]   op_a,
  input logic [OP_W-1:0]   op_b,
  input logic              busy,
  input logic              done,
  input logic [2*OP_W-1:0] product
);

  localparam int PW  = 2 * OP_W;
  localparam int CCW = $clog2(OP_W + 4) + 1;

  logic [OP_W-1:0] cap_a, cap_b;
  logic            cap_m;
  logic [CCW-1:0]  cyc_q;
  logic [PW-1:0]   model;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_a <= '0;
      cap_b <= '0;
      cap_m <= 1'b0;
      cyc_q <= '0;
    end else if (start && !busy) begin
      cap_a <= op_a;
      cap_b <= op_b;
      cap_m <= signed_mode;
      cyc_q <= '0;
    end else if (busy) begin
      cyc_q <= cyc_q + CCW'(1);
    end
  end

  always_comb begin
    if (cap_m) begin
      model = PW'($signed({{OP_W{cap_a[OP_W-1]}}, cap_a}) *
                  $signed({{OP_W{cap_b[OP_W-1]}}, cap_b}));
    end else begin
      model = PW'({{OP_W{1'b0}}, cap_a} * {{OP_W{1'b0}}, cap_b});
    end
  end

  // R1
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R1
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R2 R3
  product_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (product == model));

  // R4
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cyc_q == CCW'(OP_W + 1)));

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R5
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R7
  product_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(product));

endmodule

bind shift_add_mul shmul_chk #(.OP_W(OP_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .start       (start),
  .signed_mode (signed_mode),
  .op_a        (op_a),
  .op_b        (op_b),
  .busy        (busy),
  .done        (done),
  .product     (product)
);

// File: tb/tb_shift_add_mul.sv
module tb_shift_add_mul;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic        signed_mode;
  logic [31:0] op_a, op_b;
  logic        busy, done;
  logic [63:0] product;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [63:0] prev_exp = 64'd0;

  shift_add_mul #(.OP_W(32)) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .signed_mode (signed_mode),
    .op_a        (op_a),
    .op_b        (op_b),
    .busy        (busy),
    .done        (done),
    .product     (product)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL R4: watchdog expired, actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [63:0] ref_mul(input logic [31:0] a, input logic [31:0] b,
                                          input logic m);
    longint sa, sb;
    logic [63:0] ua, ub;
    if (m) begin
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      return 64'(sa * sb);
    end
    ua = {32'd0, a};
    ub = {32'd0, b};
    return ua * ub;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic m,
                        input bit poke);
    logic [63:0] expv;
    bit early;
    string rq;
    expv = ref_mul(a, b, m);
    rq = m ? "R3" : "R2";
    @(negedge clk);
    start = 1'b1; op_a = a; op_b = b; signed_mode = m;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1 && done === 1'b0, "R1", {62'd0, busy, done}, 64'd2);
    early = 1'b0;
    for (int i = 1; i <= 32; i++) begin
      if (poke) begin
        op_a = $urandom; op_b = $urandom; signed_mode = ~m;
        start = (i >= 4 && i <= 9);
      end
      @(posedge clk);
      @(negedge clk);
      if (done !== 1'b0) early = 1'b1;
      if (i == 16) chk(product === prev_exp, "R7", product, prev_exp);
    end
    start = 1'b0;
    chk(!early, "R4", {63'd0, early}, 64'd0);
    @(posedge clk);
    @(negedge clk);
    chk(done === 1'b1 && busy === 1'b0, poke ? "R6" : "R5", {62'd0, busy, done}, 64'd1);
    chk(product === expv, poke ? "R6" : rq, product, expv);
    @(posedge clk);
    @(negedge clk);
    chk(done === 1'b0, "R5", {63'd0, done}, 64'd0);
    chk(product === expv, "R7", product, expv);
    prev_exp = expv;
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; start = 1'b0; signed_mode = 1'b0; op_a = '0; op_b = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: state during reset
    chk(busy === 1'b0 && done === 1'b0, "R8", {62'd0, busy, done}, 64'd0);
    chk(product === 64'd0, "R8", product, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && product === 64'd0, "R8", product, 64'd0);

    // R2 directed unsigned corners
    run_op(32'd0, 32'hFFFF_FFFF, 1'b0, 1'b0);
    run_op(32'd1, 32'd1, 1'b0, 1'b0);
    run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0);
    run_op(32'h8000_0000, 32'd2, 1'b0, 1'b0);
    // R3 directed signed corners, including the most negative value
    run_op(32'h8000_0000, 32'h8000_0000, 1'b1, 1'b0);
    run_op(32'h8000_0000, 32'd1, 1'b1, 1'b0);
    run_op(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 1'b0);
    run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b0);
    run_op(32'hFFFF_FFFF, 32'd7, 1'b1, 1'b0);
    run_op(32'd0, 32'h8000_0000, 1'b1, 1'b0);
    // R6 inputs disturbed while busy
    run_op(32'h1234_5678, 32'h9ABC_DEF0, 1'b0, 1'b1);
    run_op(32'hFFFF_FFFD, 32'd3, 1'b1, 1'b1);

    for (int k = 0; k < 60; k++) begin
      logic [31:0] ra, rb;
      ra = $urandom;
      rb = $urandom;
      if (k % 7 == 3) ra = 32'h8000_0000;
      if (k % 11 == 5) rb = 32'h7FFF_FFFF;
      run_op(ra, rb, k[0], (k % 5) == 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule